// File: doc/BRIEF.md
# Vector In-Lane Element Permute Unit

This unit reorders the 32-bit elements of a vector that is 128, 256 or 512 bits wide. The vector is split into 128-bit lanes of four elements each. An element of the result can only take its value from one of the four elements of its own lane. A 2-bit selector for each result element picks that source element.

The selectors come from one of two places:
- **Immediate mode:** a shared 8-bit immediate supplies four selector fields, and every lane reuses them.
- **Variable mode:** a control vector supplies one selector per element.

When an operand is flagged as memory-sourced and broadcast is requested, its low 32-bit word is first copied into every element. That operand is the data vector in immediate mode and the control vector in variable mode.

The permuted elements then pass through per-element writemasking, either merging with the old destination or zeroing. Everything above the active vector length is cleared. Two encodings are illegal: a set width bit, or, in immediate mode, a register-specifier field other than all ones. Either one raises an error flag and returns the old destination image untouched.

Operands are captured on a valid strobe. The result, the error flag and an output valid appear on the following clock. Data bits are moved exactly as they are, with no floating-point interpretation.

Top module: `lane_permute_unit`

## Requirements
- R1: The length code `vlen` selects how many elements are active. Code 0 gives 4 elements (128 bits), code 1 gives 8 elements (256 bits), and codes 2 and 3 give 16 elements (512 bits). All result bits above the active length are zero.
- R2: Within each 128-bit lane, selector value s (0..3) places element s of that lane into the result element, bit for bit. Element s occupies lane bits [32s+31:32s].
- R3: In immediate mode (`var_mode`=0), result element k of every lane uses `imm[2k+1:2k]`. Every lane uses the same four fields.
- R4: In variable mode (`var_mode`=1), the selector for result element e is bits [1:0] of 32-bit element e of `ctl_vec`. Bits [31:2] of each control element have no effect.
- R5: In immediate mode with `bcast`=1 and `src_mem`=1, `src_data[31:0]` replaces every data element before selection. If either flag is 0, no replication happens.
- R6: In variable mode with `bcast`=1 and `src_mem`=1, `ctl_vec[31:0]` serves as the control element for every result element.
- R7: With `mask_en`=0 every active element receives its permuted value. With `mask_en`=1, an active element e whose `mask[e]` is 1 receives its permuted value.
- R8: With `mask_en`=1 and `zero_mask`=0, an active element whose mask bit is 0 keeps its value from `dest_old`.
- R9: With `mask_en`=1 and `zero_mask`=1, an active element whose mask bit is 0 becomes zero.
- R10: The error flag `out_illegal` is 1 when `wbit`=1, or when `var_mode`=0 and `spec` is not 4'b1111. While it is set, `out_data` equals `dest_old` in full.
- R11: The operands present at a clock edge with `in_valid`=1 produce `out_data`, `out_illegal` and `out_valid`=1 after that edge. Without `in_valid`, `out_valid` is 0 and `out_data` holds its value. A synchronous active-high `rst` clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| vlen | input | 2 | Vector length code |
| var_mode | input | 1 | 1: selectors from control vector, 0: from immediate |
| bcast | input | 1 | Broadcast request |
| src_mem | input | 1 | Broadcast-eligible operand comes from memory |
| mask_en | input | 1 | Writemask in use |
| zero_mask | input | 1 | 1: zero masked-off elements, 0: merge |
| wbit | input | 1 | Width bit of the encoding |
| spec | input | 4 | Unused register-specifier field |
| imm | input | 8 | Immediate selector byte |
| src_data | input | 512 | Data vector |
| ctl_vec | input | 512 | Control vector |
| mask | input | 16 | Per-element writemask |
| dest_old | input | 512 | Previous destination image |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | Result vector |
| out_illegal | output | 1 | Illegal-encoding flag |

## Verification
The immediate tests cover several cases:
- an identity byte and a lane-reversing byte, which separate correct field ordering from swapped fields;
- a splat byte, which shows that all lanes reuse the same fields.

The variable-mode tests give each element its own selector and fill the upper control bits with ones, which exposes any leak from the ignored bits. The broadcast tests toggle the memory flag, to tell a gated replication from an unconditional one. The masking tests use alternating and sparse masks under both merge and zero behaviour at every length, and a random sweep crosses all mode, length and flag combinations against a reference model.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

    localparam int ELEM_W     = 32;
    localparam int LANE_ELEMS = 4;
    localparam int MAX_ELEMS  = 16;
    localparam int VEC_W      = ELEM_W * MAX_ELEMS;
    localparam int LANE_W     = ELEM_W * LANE_ELEMS;
    localparam int SEL_W      = $clog2(LANE_ELEMS);
    localparam int CNT_W      = $clog2(MAX_ELEMS) + 1;
    localparam int IMM_W      = SEL_W * LANE_ELEMS;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_512X = 2'd3
    } vlen_e;

    typedef struct packed {
        logic       var_mode;
        logic       bcast;
        logic       src_mem;
        logic       mask_en;
        logic       zero_mask;
        logic       wbit;
        logic [3:0] spec;
    } op_ctl_t;

    function automatic logic [CNT_W-1:0] active_count(input vlen_e v);
        case (v)
            VL_128:  return CNT_W'(LANE_ELEMS);
            VL_256:  return CNT_W'(2 * LANE_ELEMS);
            default: return CNT_W'(MAX_ELEMS);
        endcase
    endfunction

    function automatic logic encoding_bad(input op_ctl_t c);
        return c.wbit || (!c.var_mode && (c.spec != 4'hF));
    endfunction

endpackage

// File: rtl/lperm_prep.sv
module lperm_prep
    import lperm_pkg::*;
#(
    parameter int EW = ELEM_W,
    parameter int NE = MAX_ELEMS
) (
    input  op_ctl_t          ctl,
    input  logic [EW*NE-1:0] src_in,
    input  logic [EW*NE-1:0] ctl_in,
    output logic [EW*NE-1:0] src_eff,
    output logic [EW*NE-1:0] ctl_eff
);
    logic rep_src;
    logic rep_ctl;

    assign rep_src = ctl.bcast && ctl.src_mem && !ctl.var_mode;
    assign rep_ctl = ctl.bcast && ctl.src_mem &&  ctl.var_mode;

    for (genvar e = 0; e < NE; e++) begin : g_elem
        assign src_eff[e*EW +: EW] = rep_src ? src_in[EW-1:0] : src_in[e*EW +: EW];
        assign ctl_eff[e*EW +: EW] = rep_ctl ? ctl_in[EW-1:0] : ctl_in[e*EW +: EW];
    end
endmodule

// File: rtl/lperm_lane.sv
module lperm_lane
    import lperm_pkg::*;
#(
    parameter int EW = ELEM_W,
    parameter int LE = LANE_ELEMS
) (
    input  logic [EW*LE-1:0]        lane_in,
    input  logic [SEL_W*LE-1:0]     sels,
    output logic [EW*LE-1:0]        lane_out
);
    for (genvar k = 0; k < LE; k++) begin : g_pick
        logic [SEL_W-1:0] s;
        assign s = sels[k*SEL_W +: SEL_W];
        always_comb begin
            lane_out[k*EW +: EW] = '0;
            for (int j = 0; j < LE; j++) begin
                if (s == SEL_W'(j)) lane_out[k*EW +: EW] = lane_in[j*EW +: EW];
            end
        end
    end
endmodule

// File: rtl/lperm_wb.sv
module lperm_wb
    import lperm_pkg::*;
#(
    parameter int EW = ELEM_W,
    parameter int NE = MAX_ELEMS
) (
    input  op_ctl_t          ctl,
    input  vlen_e            vl,
    input  logic [EW*NE-1:0] perm,
    input  logic [EW*NE-1:0] dest_old,
    input  logic [NE-1:0]    mask,
    output logic [EW*NE-1:0] result
);
    logic [CNT_W-1:0] n_act;
    logic             bad;

    assign n_act = active_count(vl);
    assign bad   = encoding_bad(ctl);

    for (genvar e = 0; e < NE; e++) begin : g_elem
        logic in_len;
        logic take;
        assign in_len = (CNT_W'(e) < n_act);
        assign take   = !ctl.mask_en || mask[e];
        always_comb begin
            if (bad)
                result[e*EW +: EW] = dest_old[e*EW +: EW];
            else if (!in_len)
                result[e*EW +: EW] = '0;
            else if (take)
                result[e*EW +: EW] = perm[e*EW +: EW];
            else if (ctl.zero_mask)
                result[e*EW +: EW] = '0;
            else
                result[e*EW +: EW] = dest_old[e*EW +: EW];
        end
    end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import lperm_pkg::*;
#(
    parameter int EW = ELEM_W,
    parameter int NE = MAX_ELEMS,
    parameter int LE = LANE_ELEMS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         vlen,
    input  logic               var_mode,
    input  logic               bcast,
    input  logic               src_mem,
    input  logic               mask_en,
    input  logic               zero_mask,
    input  logic               wbit,
    input  logic [3:0]         spec,
    input  logic [7:0]         imm,
    input  logic [EW*NE-1:0]   src_data,
    input  logic [EW*NE-1:0]   ctl_vec,
    input  logic [NE-1:0]      mask,
    input  logic [EW*NE-1:0]   dest_old,
    output logic               out_valid,
    output logic [EW*NE-1:0]   out_data,
    output logic               out_illegal
);
    localparam int NLANES = NE / LE;

    op_ctl_t          ctl;
    vlen_e            vl;
    logic [EW*NE-1:0] src_eff;
    logic [EW*NE-1:0] ctl_eff;
    logic [EW*NE-1:0] perm;
    logic [EW*NE-1:0] result;
    logic             bad;

    assign ctl = '{var_mode: var_mode, bcast: bcast, src_mem: src_mem,
                   mask_en: mask_en, zero_mask: zero_mask, wbit: wbit, spec: spec};
    assign vl  = vlen_e'(vlen);
    assign bad = encoding_bad(ctl);

    lperm_prep #(.EW(EW), .NE(NE)) u_prep (
        .ctl     (ctl),
        .src_in  (src_data),
        .ctl_in  (ctl_vec),
        .src_eff (src_eff),
        .ctl_eff (ctl_eff)
    );

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [SEL_W*LE-1:0] sels;
        for (genvar k = 0; k < LE; k++) begin : g_sel
            assign sels[k*SEL_W +: SEL_W] = var_mode ?
                ctl_eff[(l*LE+k)*EW +: SEL_W] : imm[k*SEL_W +: SEL_W];
        end
        lperm_lane #(.EW(EW), .LE(LE)) u_lane (
            .lane_in  (src_eff[l*LE*EW +: LE*EW]),
            .sels     (sels),
            .lane_out (perm[l*LE*EW +: LE*EW])
        );
    end

    lperm_wb #(.EW(EW), .NE(NE)) u_wb (
        .ctl      (ctl),
        .vl       (vl),
        .perm     (perm),
        .dest_old (dest_old),
        .mask     (mask),
        .result   (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data    <= result;
                out_illegal <= bad;
            end
        end
    end

    // Illegal width bit flags the op and returns the old image
    assert_wbit_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wbit) |=> (out_illegal && out_data == $past(dest_old)));

    // Specifier must be all ones in immediate mode
    assert_spec_checked_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !var_mode && spec != 4'hF) |=> out_illegal);

    // 128-bit length clears everything above the first lane
    assert_upper_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bad && vlen == 2'd0) |=> (out_data[EW*NE-1:LE*EW] == '0));

    // Zero masking with an empty mask yields an all-zero vector
    assert_zero_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bad && mask_en && zero_mask && mask == '0) |=> (out_data == '0));

    // Merge masking with an empty mask at full length keeps the old image
    assert_merge_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bad && mask_en && !zero_mask && mask == '0 && vlen[1])
        |=> (out_data == $past(dest_old)));

    // Valid follows the strobe by one clock; data holds when idle
    assert_valid_latency_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));
endmodule

// File: tb/tb_lane_permute_unit.sv
`timescale 1ns/1ps
module tb_lane_permute_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   vlen;
    logic         var_mode, bcast, src_mem, mask_en, zero_mask, wbit;
    logic [3:0]   spec;
    logic [7:0]   imm;
    logic [511:0] src_data, ctl_vec, dest_old;
    logic [15:0]  mask;
    logic         out_valid, out_illegal;
    logic [511:0] out_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lane_permute_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vlen(vlen),
        .var_mode(var_mode), .bcast(bcast), .src_mem(src_mem),
        .mask_en(mask_en), .zero_mask(zero_mask), .wbit(wbit), .spec(spec),
        .imm(imm), .src_data(src_data), .ctl_vec(ctl_vec), .mask(mask),
        .dest_old(dest_old), .out_valid(out_valid), .out_data(out_data),
        .out_illegal(out_illegal)
    );

    function automatic logic [511:0] model();
        logic [511:0] r;
        int n;
        n = (vlen == 2'd0) ? 4 : (vlen == 2'd1) ? 8 : 16;
        if (wbit || (!var_mode && spec != 4'hF)) return dest_old;
        r = '0;
        for (int e = 0; e < n; e++) begin
            logic [31:0] cw, v;
            logic [1:0]  s;
            cw = (var_mode && bcast && src_mem) ? ctl_vec[31:0] : ctl_vec[e*32 +: 32];
            s  = var_mode ? cw[1:0] : imm[2*(e%4) +: 2];
            v  = (!var_mode && bcast && src_mem) ? src_data[31:0]
                                                 : src_data[((e/4)*4 + s)*32 +: 32];
            if (!mask_en || mask[e])  r[e*32 +: 32] = v;
            else if (zero_mask)       r[e*32 +: 32] = 32'h0;
            else                      r[e*32 +: 32] = dest_old[e*32 +: 32];
        end
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic defaults();
        vlen = 2'd2; var_mode = 0; bcast = 0; src_mem = 0; mask_en = 0;
        zero_mask = 0; wbit = 0; spec = 4'hF; imm = 8'hE4; mask = '0;
        for (int e = 0; e < 16; e++) begin
            src_data[e*32 +: 32] = 32'h7FC0_0000 + 32'(e * 32'h0101_0011);
            dest_old[e*32 +: 32] = 32'hD000_0000 + 32'(e);
            ctl_vec[e*32 +: 32]  = 32'h0;
        end
    endtask

    // Drive one op at a negedge, sample its result one clock later
    task automatic fire(input string tag);
        logic [511:0] exp;
        logic         bad;
        exp = model();
        bad = wbit || (!var_mode && spec != 4'hF);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({tag, " R11 valid"}, out_valid, 1'b1);
        check_bit({tag, " R10 flag"}, out_illegal, bad);
        check_vec(tag, out_data, exp);
    endtask

    task automatic t_reset();
        check_bit("R11 reset valid", out_valid, 1'b0);
        check_bit("R11 reset illegal", out_illegal, 1'b0);
        check_vec("R11 reset data", out_data, '0);
    endtask

    task automatic t_imm();
        logic [511:0] exp;
        defaults();
        imm = 8'hE4; exp = src_data;
        fire("R3 identity");
        check_vec("R2 identity literal", out_data, exp);
        imm = 8'h1B;
        for (int e = 0; e < 16; e++) exp[e*32 +: 32] = src_data[((e/4)*4 + 3 - e%4)*32 +: 32];
        fire("R3 reverse");
        check_vec("R2 reverse literal", out_data, exp);
        imm = 8'hAA; fire("R3 splat2");
        imm = 8'h9C; vlen = 2'd1; fire("R1 256 imm");
        vlen = 2'd3; fire("R1 code3");
    endtask

    task automatic t_var();
        defaults();
        var_mode = 1; spec = 4'h0;
        for (int e = 0; e < 16; e++)
            ctl_vec[e*32 +: 32] = {30'h3FFF_FFFF, 2'((e * 3 + 1) % 4)};
        fire("R4 var high bits set");
        for (int e = 0; e < 16; e++) ctl_vec[e*32 +: 32] = 32'hFFFF_FFFC;
        fire("R4 var sel0");
        check_vec("R4 sel0 lane0 literal", {448'h0, {4{src_data[31:0]}}},
                  {448'h0, out_data[127:0]});
    endtask

    task automatic t_bcast();
        defaults();
        imm = 8'h1B; bcast = 1; src_mem = 0; fire("R5 no mem");
        src_mem = 1; fire("R5 mem");
        check_vec("R5 splat literal", out_data, {16{src_data[31:0]}});
        var_mode = 1;
        for (int e = 0; e < 16; e++) ctl_vec[e*32 +: 32] = 32'(e % 4);
        ctl_vec[31:0] = 32'h0000_0102; fire("R6 ctl bcast");
        src_mem = 0; fire("R6 no mem");
    endtask

    task automatic t_mask();
        defaults();
        imm = 8'h4E;
        for (int v = 0; v < 3; v++) begin
            vlen = 2'(v);
            mask_en = 1; mask = 16'hA5C3;
            zero_mask = 0; fire("R8 merge");
            zero_mask = 1; fire("R9 zero");
            mask = 16'hFFFF; fire("R7 all ones");
            mask_en = 0; mask = 16'h0; fire("R7 no mask");
        end
        mask_en = 1; zero_mask = 0; mask = 16'h0; vlen = 2'd2;
        fire("R8 keep all");
        check_vec("R8 keep literal", out_data, dest_old);
        vlen = 2'd0; mask = 16'hFFFF; fire("R1 128 clear");
        check_vec("R1 upper literal", {out_data[511:128], 128'h0}, 512'h0);
    endtask

    task automatic t_illegal();
        defaults();
        wbit = 1; fire("R10 wbit");
        wbit = 0; spec = 4'h7; fire("R10 spec imm");
        var_mode = 1; fire("R10 spec var ok");
        var_mode = 0; spec = 4'hF; vlen = 2'd0; wbit = 1; fire("R10 wbit 128");
    endtask

    task automatic t_hold();
        logic [511:0] last;
        last = out_data;
        @(negedge clk);
        check_bit("R11 idle valid", out_valid, 1'b0);
        check_vec("R11 idle hold", out_data, last);
    endtask

    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            vlen = 2'($urandom); var_mode = 1'($urandom); bcast = 1'($urandom);
            src_mem = 1'($urandom); mask_en = 1'($urandom); zero_mask = 1'($urandom);
            wbit = ($urandom % 8) == 0; spec = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            imm = 8'($urandom); mask = 16'($urandom);
            for (int e = 0; e < 16; e++) begin
                src_data[e*32 +: 32] = $urandom;
                ctl_vec[e*32 +: 32]  = $urandom;
                dest_old[e*32 +: 32] = $urandom;
            end
            fire("R2 random sweep");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; in_valid = 0;
        defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_imm();
        t_hold();
        t_var();
        t_bcast();
        t_mask();
        t_illegal();
        t_hold();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule